// File: doc/BRIEF.md
# Multiplexed-Bus Pseudo-SRAM Write Controller

This block sits on the host side of a pseudo-SRAM whose sixteen low address bits share their wires with the data. It takes a single write request and runs one complete write on the memory pins. The request carries a 21-bit word address, a 16-bit data word and two byte-enable bits, and is launched with a one-cycle start strobe. The block answers with a one-cycle done pulse.

Each write runs in a fixed order. The controller selects the chip and drives the full address. It then pulses the address-latch strobe low so that the memory captures the low address bits from the shared bus. Next it switches the shared bus over to the write data and pulls write-enable low, together with the selected byte lanes, for a timed write window. It ends the write by raising write-enable and the lanes together. It then holds the data and the chip select for a hold time, releases the bus, and waits out a recovery gap before it reports done.

Every setup, hold and pulse width is a parameter counted in system clocks. All memory pins come straight from registers, so they change only on clock edges and cannot glitch.

Top module: `mux_psram_wr`

## Requirements
- R1: While reset is applied and after it is released, memCsN, memAdvN, memWeN, memUbN and memLbN are high, and memAdqOe, busyOut and doneOut are low.
- R2: memCsN falls exactly T_AS cycles before memAdvN falls. memAdvN stays low for exactly T_ADV cycles. In every cycle with memAdvN low, memAdqOe is high, memAdqOut equals request address bits 15:0 and memAddrHi equals request address bits 20:16.
- R3: memWeN falls exactly T_AH + T_DS cycles after memAdvN rises.
- R4: memWeN stays low for exactly T_WP cycles. During that window and until memCsN rises, memAdqOe is high, memCsN is low and memAdqOut equals the request data.
- R5: Byte-enable bit 1 selects memUbN and bit 0 selects memLbN. A selected lane is low in exactly the cycles where memWeN is low. An unselected lane stays high.
- R6: With both byte-enable bits zero, memUbN and memLbN stay high for the whole cycle, so nothing is written.
- R7: memWeN and the lane outputs rise in the same cycle. memCsN rises exactly T_DH cycles later, and memAdqOe falls in that same cycle. memAdqOe rises in the same cycle as the memCsN fall.
- R8: After memCsN rises, all control pins stay inactive and memAdqOe stays low for exactly T_REC cycles. doneOut then pulses high for exactly one cycle.
- R9: busyOut rises in the same cycle as the memCsN fall. It stays high through the doneOut cycle and is low in the cycle after it.
- R10: A start that arrives while busyOut is high and doneOut is low is dropped. The request inputs are sampled only when a start is accepted, so changing them later has no effect on the pins.
- R11: A start presented in the doneOut cycle is accepted. Its memCsN fall comes exactly T_REC + 2 cycles after the previous memCsN rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request strobe |
| reqAddr | input | 21 | Word address of the write |
| reqData | input | 16 | Write data |
| reqBe | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| doneOut | output | 1 | One-cycle pulse when the write cycle has finished |
| busyOut | output | 1 | High while a write cycle is in progress |
| memCsN | output | 1 | Chip select, active low |
| memAdvN | output | 1 | Address-latch strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memUbN | output | 1 | Upper byte lane enable, active low |
| memLbN | output | 1 | Lower byte lane enable, active low |
| memAddrHi | output | 5 | Dedicated address bits 20:16 |
| memAdqOut | output | 16 | Shared address/data bus, outgoing value |
| memAdqOe | output | 1 | Output enable for the shared bus |

## Verification
Each state of the sequencer drives one fixed combination of pin levels. A wrong state or a miscounted interval therefore shows up at the pins in the very next cycle, as a pin edge that comes too early or too late compared with the other pins. The bench measures every edge position relative to the memCsN fall. Wrong latched request contents show up on the shared bus during the ADV or write window. A dropped or duplicated cycle shows up as an extra or missing memCsN fall within a few cycles of doneOut.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_SETUP,
    ST_ADV_PULSE,
    ST_ADDR_HOLD,
    ST_DATA_DRIVE,
    ST_WRITE_PULSE,
    ST_DATA_HOLD,
    ST_RECOVER,
    ST_DONE
  } wrState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // capture request
    logic csAct;    // chip select active
    logic advAct;   // address latch active
    logic weAct;    // write window active
    logic busDrv;   // drive shared bus
    logic selData;  // shared bus carries data, else address
    logic done;     // completion pulse
    logic busy;     // cycle in flight
  } wrStrobe_t;

endpackage

// File: rtl/psram_wr_ctrl.sv
module psram_wr_ctrl
  import psram_wr_pkg::*;
#(
  parameter int T_AS  = 2,
  parameter int T_ADV = 2,
  parameter int T_AH  = 1,
  parameter int T_DS  = 1,
  parameter int T_WP  = 3,
  parameter int T_DH  = 2,
  parameter int T_REC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  output wrStrobe_t  strobe
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_T = maxOf(maxOf(maxOf(T_AS, T_ADV), maxOf(T_AH, T_DS)),
                               maxOf(maxOf(T_WP, T_DH), T_REC));
  localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);

  wrState_e          state, nextState;
  logic [CNT_W-1:0]  cnt;
  logic              cntZero;

  assign cntZero = (cnt == '0);

  // reload value is the state length minus one
  function automatic logic [CNT_W-1:0] loadFor(input wrState_e s);
    case (s)
      ST_ADDR_SETUP:  return CNT_W'(T_AS - 1);
      ST_ADV_PULSE:   return CNT_W'(T_ADV - 1);
      ST_ADDR_HOLD:   return CNT_W'(T_AH - 1);
      ST_DATA_DRIVE:  return CNT_W'(T_DS - 1);
      ST_WRITE_PULSE: return CNT_W'(T_WP - 1);
      ST_DATA_HOLD:   return CNT_W'(T_DH - 1);
      ST_RECOVER:     return CNT_W'(T_REC - 1);
      default:        return '0;
    endcase
  endfunction

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:        if (startReq) nextState = ST_ADDR_SETUP;
      ST_ADDR_SETUP:  if (cntZero)  nextState = ST_ADV_PULSE;
      ST_ADV_PULSE:   if (cntZero)  nextState = ST_ADDR_HOLD;
      ST_ADDR_HOLD:   if (cntZero)  nextState = ST_DATA_DRIVE;
      ST_DATA_DRIVE:  if (cntZero)  nextState = ST_WRITE_PULSE;
      ST_WRITE_PULSE: if (cntZero)  nextState = ST_DATA_HOLD;
      ST_DATA_HOLD:   if (cntZero)  nextState = ST_RECOVER;
      ST_RECOVER:     if (cntZero)  nextState = ST_DONE;
      ST_DONE:                      nextState = ST_IDLE;
      default:                      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        cnt <= loadFor(nextState);
      end else if (!cntZero) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == ST_IDLE) && startReq;
    strobe.busy    = (state != ST_IDLE);
    strobe.done    = (state == ST_DONE);
    strobe.advAct  = (state == ST_ADV_PULSE);
    strobe.weAct   = (state == ST_WRITE_PULSE);
    strobe.selData = (state == ST_DATA_DRIVE) || (state == ST_WRITE_PULSE) ||
                     (state == ST_DATA_HOLD);
    strobe.csAct   = (state == ST_ADDR_SETUP) || (state == ST_ADV_PULSE) ||
                     (state == ST_ADDR_HOLD)  || strobe.selData;
    strobe.busDrv  = strobe.csAct;
  end

endmodule

// File: rtl/psram_wr_dp.sv
module psram_wr_dp
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wrStrobe_t                   strobe,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqData,
  input  logic [DATA_W/8-1:0]         reqBe,
  output logic                        csN,
  output logic                        advN,
  output logic                        weN,
  output logic [DATA_W/8-1:0]         laneN,
  output logic [ADDR_W-DATA_W-1:0]    addrHi,
  output logic [DATA_W-1:0]           adqOut,
  output logic                        adqOe,
  output logic                        done,
  output logic                        busy
);

  localparam int LANES = DATA_W / 8;
  localparam int HI_W  = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  beQ;

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
    end else if (strobe.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      beQ   <= reqBe;
    end
  end

  // registered pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csN    <= 1'b1;
      advN   <= 1'b1;
      weN    <= 1'b1;
      adqOe  <= 1'b0;
      adqOut <= '0;
      addrHi <= '0;
      done   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      csN    <= ~strobe.csAct;
      advN   <= ~strobe.advAct;
      weN    <= ~strobe.weAct;
      adqOe  <= strobe.busDrv;
      adqOut <= strobe.selData ? dataQ : addrQ[DATA_W-1:0];
      addrHi <= addrQ[ADDR_W-1 -: HI_W];
      done   <= strobe.done;
      busy   <= strobe.busy;
    end
  end

  // one lane register per byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) laneN[g] <= 1'b1;
      else        laneN[g] <= ~(strobe.weAct & beQ[g]);
    end
  end

endmodule

// File: rtl/mux_psram_wr.sv
module mux_psram_wr
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int T_AS   = 2,
  parameter int T_ADV  = 2,
  parameter int T_AH   = 1,
  parameter int T_DS   = 1,
  parameter int T_WP   = 3,
  parameter int T_DH   = 2,
  parameter int T_REC  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     startReq,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqData,
  input  logic [1:0]               reqBe,
  output logic                     doneOut,
  output logic                     busyOut,
  output logic                     memCsN,
  output logic                     memAdvN,
  output logic                     memWeN,
  output logic                     memUbN,
  output logic                     memLbN,
  output logic [ADDR_W-DATA_W-1:0] memAddrHi,
  output logic [DATA_W-1:0]        memAdqOut,
  output logic                     memAdqOe
);

  localparam int LANES = DATA_W / 8;

  wrStrobe_t        strobe;
  logic [LANES-1:0] laneN;

  psram_wr_ctrl #(
    .T_AS(T_AS), .T_ADV(T_ADV), .T_AH(T_AH), .T_DS(T_DS),
    .T_WP(T_WP), .T_DH(T_DH), .T_REC(T_REC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .strobe   (strobe)
  );

  psram_wr_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .reqBe   (reqBe),
    .csN     (memCsN),
    .advN    (memAdvN),
    .weN     (memWeN),
    .laneN   (laneN),
    .addrHi  (memAddrHi),
    .adqOut  (memAdqOut),
    .adqOe   (memAdqOe),
    .done    (doneOut),
    .busy    (busyOut)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];

endmodule

// File: rtl/psram_wr_chk.sv
module psram_wr_chk (
  input logic clk,
  input logic rst_n,
  input logic doneOut,
  input logic busyOut,
  input logic memCsN,
  input logic memAdvN,
  input logic memWeN,
  input logic memUbN,
  input logic memLbN,
  input logic memAdqOe,
  input logic [15:0] memAdqOut
);

  // R4
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> (!memCsN && memAdqOe && memAdvN));

  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!memWeN && !$past(memWeN)) |-> $stable(memAdqOut));

  // R5
  lane_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!memUbN || !memLbN) |-> !memWeN);

  // R2
  adv_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !memAdvN |-> (memAdqOe && !memCsN));

  // R7
  cs_held_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> !memCsN);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busyOut |-> (memCsN && !memAdqOe && memWeN));

endmodule

bind mux_psram_wr psram_wr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .doneOut   (doneOut),
  .busyOut   (busyOut),
  .memCsN    (memCsN),
  .memAdvN   (memAdvN),
  .memWeN    (memWeN),
  .memUbN    (memUbN),
  .memLbN    (memLbN),
  .memAdqOe  (memAdqOe),
  .memAdqOut (memAdqOut)
);

// File: tb/sim_mux_psram_wr.sv
module sim_mux_psram_wr;

  localparam int T_AS  = 2;
  localparam int T_ADV = 2;
  localparam int T_AH  = 1;
  localparam int T_DS  = 1;
  localparam int T_WP  = 3;
  localparam int T_DH  = 2;
  localparam int T_REC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startReq = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [1:0]  reqBe = '0;
  logic        doneOut, busyOut, memCsN, memAdvN, memWeN, memUbN, memLbN, memAdqOe;
  logic [4:0]  memAddrHi;
  logic [15:0] memAdqOut;

  int testsRun = 0;
  int testsFailed = 0;
  int gcyc = 0;
  int lastCsRise = 0;
  int lastCsFall = 0;

  always #10 clk = ~clk;
  always @(posedge clk) gcyc <= gcyc + 1;

  mux_psram_wr #(
    .T_AS(T_AS), .T_ADV(T_ADV), .T_AH(T_AH), .T_DS(T_DS),
    .T_WP(T_WP), .T_DH(T_DH), .T_REC(T_REC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .reqAddr(reqAddr),
    .reqData(reqData), .reqBe(reqBe), .doneOut(doneOut), .busyOut(busyOut),
    .memCsN(memCsN), .memAdvN(memAdvN), .memWeN(memWeN), .memUbN(memUbN),
    .memLbN(memLbN), .memAddrHi(memAddrHi), .memAdqOut(memAdqOut),
    .memAdqOe(memAdqOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drives one write from the current negedge and follows it to doneOut
  task automatic runWrite(input logic [20:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit inject);
    int csF = -1, csR = -1, advF = -1, advR = -1, weF = -1, weR = -1;
    int oeR = -1, oeF = -1, busyR = -1, doneC = -1, lbF = -1, ubF = -1;
    bit addrBad = 0, dataBad = 0, laneBad = 0, idleBad = 0, busyBad = 0;
    startReq = 1'b1; reqAddr = a; reqData = d; reqBe = be;
    @(negedge clk);
    startReq = 1'b0; reqAddr = ~a; reqData = ~d; reqBe = ~be;
    for (int k = 0; k < 300 && doneC < 0; k++) begin
      if (inject && k == 3) begin startReq = 1'b1; reqData = 16'h0F0F; end
      if (inject && k == 4) startReq = 1'b0;
      if (csF < 0 && !memCsN) csF = k;
      if (csF >= 0 && csR < 0 && memCsN) csR = k;
      if (advF < 0 && !memAdvN) advF = k;
      if (advF >= 0 && advR < 0 && memAdvN) advR = k;
      if (weF < 0 && !memWeN) weF = k;
      if (weF >= 0 && weR < 0 && memWeN) weR = k;
      if (ubF < 0 && !memUbN) ubF = k;
      if (lbF < 0 && !memLbN) lbF = k;
      if (oeR < 0 && memAdqOe) oeR = k;
      if (oeR >= 0 && oeF < 0 && !memAdqOe) oeF = k;
      if (busyR < 0 && busyOut) busyR = k;
      if (busyR >= 0 && !busyOut) busyBad = 1;
      if (!memAdvN && (memAdqOut != a[15:0] || memAddrHi != a[20:16] || !memAdqOe))
        addrBad = 1;
      if (weF >= 0 && !memCsN && (memAdqOut != d || !memAdqOe)) dataBad = 1;
      if (memUbN != (memWeN | ~be[1]) || memLbN != (memWeN | ~be[0])) laneBad = 1;
      if (csR >= 0 && !doneOut && (!memCsN || !memAdvN || !memWeN || !memUbN ||
          !memLbN || memAdqOe)) idleBad = 1;
      if (doneOut) doneC = k;
      else @(negedge clk);
    end
    check(csF >= 0 && doneC >= 0, "R8 cycle completes", doneC, 1);
    check(advF - csF == T_AS, "R2 CS to ADV fall", advF - csF, T_AS);
    check(advR - advF == T_ADV, "R2 ADV low width", advR - advF, T_ADV);
    check(!addrBad, "R2 address on bus during ADV", addrBad, 0);
    check(weF - advR == T_AH + T_DS, "R3 ADV rise to WE fall", weF - advR, T_AH + T_DS);
    check(weR - weF == T_WP, "R4 WE low width", weR - weF, T_WP);
    check(!dataBad, "R4 R10 data on bus", dataBad, 0);
    if (be == 2'b00) check(!laneBad && ubF < 0 && lbF < 0, "R6 lanes idle", laneBad, 0);
    else check(!laneBad, "R5 lane pattern", laneBad, 0);
    check(csR - weR == T_DH, "R7 WE rise to CS rise", csR - weR, T_DH);
    check(oeR == csF && oeF == csR, "R7 OE span", oeF, csR);
    check(doneC - csR == T_REC, "R8 recovery length", doneC - csR, T_REC);
    check(!idleBad, "R8 pins quiet in recovery", idleBad, 0);
    check(busyR == csF && !busyBad, "R9 busy span", busyR, csF);
    lastCsFall = gcyc - (doneC - csF);
    lastCsRise = gcyc - (doneC - csR);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(memCsN && memAdvN && memWeN && memUbN && memLbN, "R1 controls high", 0, 1);
    check(!memAdqOe && !busyOut && !doneOut, "R1 outputs low", memAdqOe, 0);
  endtask

  task automatic testSingle(input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
    runWrite(a, d, be, 1'b0);
    @(negedge clk);
    check(!busyOut && !doneOut, "R9 busy low after done", busyOut, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic testDrop();
    bit extra = 0;
    runWrite(21'h0ABCD, 16'h5A5A, 2'b11, 1'b1);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!memCsN || busyOut) extra = 1;
    end
    check(!extra, "R10 start while busy dropped", extra, 0);
  endtask

  task automatic testBackToBack();
    int rise1;
    runWrite(21'h12345, 16'hBEEF, 2'b11, 1'b0);
    rise1 = lastCsRise;
    runWrite(21'h054321, 16'hCAFE, 2'b01, 1'b0);
    check(lastCsFall - rise1 == T_REC + 2, "R11 back-to-back gap", lastCsFall - rise1, T_REC + 2);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d", gcyc, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(memCsN && !busyOut && !memAdqOe, "R1 during reset", busyOut, 0);
    rst_n = 1'b1;
    testReset();
    testSingle(21'h1F_1234, 16'hA55A, 2'b11);
    testSingle(21'h00_8001, 16'h1234, 2'b10);
    testSingle(21'h0A_FFFF, 16'h00FF, 2'b01);
    testSingle(21'h15_0000, 16'hFFFF, 2'b00);
    testSingle(21'h1F_FFFF, 16'h0000, 2'b11);
    testSingle(21'h00_0000, 16'hFFFF, 2'b11);
    testDrop();
    testBackToBack();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule